// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block gives a controller access to the internal register space of a serial-link PHY through a narrow strobe/acknowledge port. Towards the PHY it drives one 32-bit control word and reads one 32-bit status word. The control word carries a 16-bit data-in field and four strobes. The status word returns an acknowledge flag and a 16-bit data-out field. Every strobe completes a four-phase exchange: raise, wait for acknowledge high, drop, wait for acknowledge low.

A command port starts one of three accesses. The first latches an address in the PHY. The second writes data to the latched address. The third reads from it. Each wait for acknowledge is polled once per programmable interval. After a fixed number of failed polls the block gives up and reports a timeout. A write whose value has bit 0 set puts the PHY into reset, and the PHY cannot answer in that state. For such a write the block raises the write strobe and finishes at once, without waiting for acknowledge.

Top module: `phy_cr_master`

## Requirements
- R1: The control word output carries data-in on bits 15:0, address capture on bit 16, data capture on bit 17, write on bit 18, read on bit 19, and on bit 20 the value of `test_pd_i`. Bits 31:21 are zero. After reset, bits 19:0 are zero.
- R2: The acknowledge flag is taken from status bit 18. Read data is taken from status bits 15:0.
- R3: A command is accepted only in a cycle where `busy_o` is low. Opcode 0 is address, opcode 1 is write and opcode 2 is read. Opcode 3, and any command offered while busy, is ignored and leaves the outputs unchanged.
- R4: An address or write command loads the data-in field one cycle before the first strobe rises. At most one strobe is high at any time.
- R5: Every strobe runs the full exchange. It is raised while acknowledge is low, held until acknowledge is seen high, dropped, and held low until acknowledge is seen low.
- R6: The first poll of a wait comes `gap` cycles after the phase starts, and later polls follow every `gap`+1 cycles. If acknowledge never changes, `timeout_o` pulses (`gap`+1)×MAX_POLLS cycles after the phase started. The block is then idle with all strobes low.
- R7: An address command runs one exchange on the address-capture strobe, with the address on data-in.
- R8: A write command first runs an exchange on the data-capture strobe, then one on the write strobe.
- R9: A write whose value has bit 0 set raises the write strobe and pulses `done_o` on that same edge, without polling. The write strobe stays high until the next command is accepted, which clears it.
- R10: A read command samples data-out on the successful poll of the high phase, while the read strobe is still high. The value is then held on `rdata_o`.
- R11: `done_o` is a single-cycle pulse at the end of a successful access. It never coincides with `timeout_o`. `busy_o` is high from the cycle after acceptance until the done or timeout pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | Opcode: 0 address, 1 write, 2 read, 3 none |
| cmd_data_i | input | 16 | Address or write data |
| poll_gap_i | input | 8 | Idle cycles between polls |
| test_pd_i | input | 1 | Level for the power-down test bit |
| ctrl_o | output | 32 | Control word to the PHY |
| stat_i | input | 32 | Status word from the PHY |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access finished successfully |
| timeout_o | output | 1 | Access abandoned |
| rdata_o | output | 16 | Last read result |

## Verification
A PHY model in the bench answers the strobes after a chosen delay and holds a small register file. Address, write and read sequences are swept over a grid of poll gaps and acknowledge delays, with patterned values. A wrong readback separates the capture order, the sample point and the field layout.

A model that never answers and one whose acknowledge is stuck high exercise timeout in the high phase and in the low phase. Their exact cycle counts show whether the poll spacing and the poll limit are right. Further cases cover:
- a reset write against a model that ignores the write strobe;
- a command offered while busy;
- the unused opcode.

Each of these shows whether a stray input is really ignored.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  localparam int unsigned BIT_CAPA = 16;
  localparam int unsigned BIT_PD   = 20;
  localparam int unsigned BIT_ACK  = 18;
  localparam int unsigned N_STB    = 4;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } cr_op_e;

  // strobe index; bit position is BIT_CAPA + index
  typedef enum logic [1:0] {
    SB_CAPA = 2'd0,
    SB_CAPD = 2'd1,
    SB_WR   = 2'd2,
    SB_RD   = 2'd3
  } cr_stb_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_HI,
    ST_LO
  } cr_state_e;
endpackage

// File: rtl/cr_poll_timer.sv
module cr_poll_timer #(
  parameter int unsigned GAP_W     = 8,
  parameter int unsigned MAX_POLLS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             run_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             tick_o,
  output logic             last_o
);
  localparam int unsigned PW = $clog2(MAX_POLLS + 1);

  logic [GAP_W-1:0] gcnt_q;
  logic [PW-1:0]    pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gcnt_q <= '0;
      pcnt_q <= '0;
    end else if (arm_i) begin
      gcnt_q <= gap_i;
      pcnt_q <= '0;
    end else if (run_i) begin
      if (gcnt_q != '0) begin
        gcnt_q <= gcnt_q - 1'b1;
      end else begin
        gcnt_q <= gap_i;
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign tick_o = run_i && (gcnt_q == '0);
  assign last_o = (pcnt_q == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/cr_word_map.sv
module cr_word_map
  import phy_cr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CTRL_W = 32
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [N_STB-1:0]  stb_i,
  input  logic              pd_i,
  input  logic [CTRL_W-1:0] stat_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] dout_o
);
  always_comb begin
    ctrl_o                     = '0;
    ctrl_o[DATA_W-1:0]         = din_i;
    ctrl_o[BIT_CAPA +: N_STB]  = stb_i;
    ctrl_o[BIT_PD]             = pd_i;
  end

  assign ack_o  = stat_i[BIT_ACK];
  assign dout_o = stat_i[DATA_W-1:0];
endmodule

// File: rtl/cr_seq.sv
module cr_seq
  import phy_cr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] sdata_i,
  input  logic              tick_i,
  input  logic              last_i,
  output logic              arm_o,
  output logic              run_o,
  output logic [N_STB-1:0]  stb_o,
  output logic [DATA_W-1:0] din_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o
);
  cr_state_e         state_q;
  cr_op_e            op_q;
  cr_stb_e           sel_q;
  logic              on_q;
  logic [DATA_W-1:0] din_q, rdata_q;
  logic              done_q, to_q;

  cr_op_e op_in;
  logic   hi_ok, lo_ok, chain_wr;

  assign op_in    = cr_op_e'(cmd_op_i);
  assign hi_ok    = (state_q == ST_HI) && tick_i && ack_i;
  assign lo_ok    = (state_q == ST_LO) && tick_i && !ack_i;
  assign chain_wr = (op_q == OP_WRITE) && (sel_q == SB_CAPD);

  // restart the poll window on every phase entry
  assign arm_o = (state_q == ST_LOAD) || hi_ok || (lo_ok && chain_wr && !din_q[0]);
  assign run_o = (state_q == ST_HI) || (state_q == ST_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ADDR;
      sel_q   <= SB_CAPA;
      on_q    <= 1'b0;
      din_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid_i && op_in != OP_NONE) begin
            op_q    <= op_in;
            on_q    <= 1'b0;
            state_q <= ST_LOAD;
            if (op_in != OP_READ) din_q <= cmd_data_i;
            unique case (op_in)
              OP_ADDR:  sel_q <= SB_CAPA;
              OP_WRITE: sel_q <= SB_CAPD;
              default:  sel_q <= SB_RD;
            endcase
          end
        end
        ST_LOAD: begin
          on_q    <= 1'b1;
          state_q <= ST_HI;
        end
        ST_HI: begin
          if (hi_ok) begin
            if (sel_q == SB_RD) rdata_q <= sdata_i;
            on_q    <= 1'b0;
            state_q <= ST_LO;
          end else if (tick_i && last_i) begin
            on_q    <= 1'b0;
            to_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_LO: begin
          if (lo_ok) begin
            if (chain_wr) begin
              sel_q <= SB_WR;
              on_q  <= 1'b1;
              if (din_q[0]) begin
                // PHY reset: it cannot acknowledge
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_HI;
              end
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (tick_i && last_i) begin
            to_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < N_STB; i++) begin : g_stb
      assign stb_o[i] = on_q && (sel_q == cr_stb_e'(i));
    end
  endgenerate

  assign din_o     = din_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CTRL_W    = 32,
  parameter int unsigned GAP_W     = 8,
  parameter int unsigned MAX_POLLS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic [GAP_W-1:0]  poll_gap_i,
  input  logic              test_pd_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic [CTRL_W-1:0] stat_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              ack, tick, last, arm, run;
  logic [DATA_W-1:0] sdata, din;
  logic [N_STB-1:0]  stb;

  cr_word_map #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_map (
    .din_i  (din),
    .stb_i  (stb),
    .pd_i   (test_pd_i),
    .stat_i (stat_i),
    .ctrl_o (ctrl_o),
    .ack_o  (ack),
    .dout_o (sdata)
  );

  cr_poll_timer #(.GAP_W(GAP_W), .MAX_POLLS(MAX_POLLS)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .run_i  (run),
    .gap_i  (poll_gap_i),
    .tick_o (tick),
    .last_o (last)
  );

  cr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_data_i  (cmd_data_i),
    .ack_i       (ack),
    .sdata_i     (sdata),
    .tick_i      (tick),
    .last_i      (last),
    .arm_o       (arm),
    .run_o       (run),
    .stb_o       (stb),
    .din_o       (din),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int unsigned CTRL_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o
);
  logic take;
  assign take = !busy_o && cmd_valid_i && (cmd_op_i != 2'd3);

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(ctrl_o[19:16])); // R4
  AST_DATA_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(|ctrl_o[19:16]) |-> $stable(ctrl_o[15:0])); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) ctrl_o[CTRL_W-1:21] == '0); // R1
  AST_TIMEOUT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni) timeout_o |-> (ctrl_o[19:16] == 4'b0 && !busy_o)); // R6
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(done_o && timeout_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R11
  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni) take |=> busy_o); // R3
  AST_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni) (!busy_o && !take) |=> !busy_o); // R3
endmodule

bind phy_cr_master phy_cr_master_chk #(.CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/tb_phy_cr_master.sv
module tb_phy_cr_master;
  localparam int MAXP = 10;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        cmd_valid_i = 0;
  logic [1:0]  cmd_op_i = 0;
  logic [15:0] cmd_data_i = 0;
  logic [7:0]  poll_gap_i = 0;
  logic        test_pd_i = 0;
  logic [31:0] ctrl_o, stat_i;
  logic        busy_o, done_o, timeout_o;
  logic [15:0] rdata_o;

  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  phy_cr_master dut (.*);

  // PHY model
  int          dly = 0;
  bit          no_ack = 0, no_ack_wr = 0, ack_stuck = 0;
  logic [7:0]  ack_sr;
  logic [15:0] mem [16];
  logic [15:0] addr_q, pend_q;
  logic [31:0] prev_c;
  bit          capd_seen;
  int          order_err, viol;
  logic        ack, want;

  assign want   = (|ctrl_o[19:16]) && !no_ack && !(no_ack_wr && ctrl_o[18]);
  assign ack    = ack_stuck ? 1'b1 : ack_sr[dly];
  assign stat_i = {13'b0, ack, 2'b0, (ctrl_o[19] ? mem[addr_q[3:0]] : 16'h0000)};

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_sr <= '0; prev_c <= '0; addr_q <= '0; pend_q <= '0; capd_seen <= 0;
    end else begin
      ack_sr <= {ack_sr[6:0], want};
      prev_c <= ctrl_o;
      if (ctrl_o[16] && !prev_c[16]) addr_q <= ctrl_o[15:0];
      if (ctrl_o[17] && !prev_c[17]) begin pend_q <= ctrl_o[15:0]; capd_seen <= 1; end
      if (ctrl_o[18] && !prev_c[18]) begin
        if (!capd_seen) order_err++;
        mem[addr_q[3:0]] <= pend_q;
        capd_seen <= 0;
      end
      if (!no_ack && !no_ack_wr && !ack_stuck) begin
        if ((|(ctrl_o[19:16] & ~prev_c[19:16])) && ack) viol++;
        if ((|(prev_c[19:16] & ~ctrl_o[19:16])) && !ack) viol++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int  cyc;
  bit  got_done, got_to;
  logic wr_at_take;

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk_i);
    cmd_valid_i = 1; cmd_op_i = op; cmd_data_i = d;
    cyc = 0; got_done = 0; got_to = 0;
    forever begin
      @(posedge clk_i); #1;
      cmd_valid_i = 0;
      cyc++;
      if (cyc == 1) wr_at_take = ctrl_o[18];
      if (done_o || timeout_o || cyc > 3000) break;
    end
    got_done = done_o; got_to = timeout_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    order_err = 0; viol = 0;
    repeat (3) @(negedge clk_i);
    chk(ctrl_o == 32'h0 && !busy_o && !done_o && !timeout_o, "R1 reset", ctrl_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    test_pd_i = 1; #1;
    chk(ctrl_o[20] == 1 && ctrl_o[31:21] == 0, "R1 pd bit", ctrl_o, 32'h100000);
    test_pd_i = 0;

    // R7 R8 R10 R2 R5: sweep gap and ack delay
    for (int g = 0; g < 3; g++) begin
      for (int d = 0; d < 4; d++) begin
        logic [15:0] a, v;
        poll_gap_i = 8'(g); dly = d;
        a = 16'((g * 4 + d) & 15);
        v = (16'hA5C0 ^ 16'(g << 9) ^ 16'(d << 5) ^ 16'(a << 1)) & 16'hFFFE;
        run_cmd(2'd0, a);
        chk(got_done && !got_to, "R7 addr done", {got_done, got_to}, 2);
        run_cmd(2'd1, v);
        chk(got_done && !got_to, "R8 write done", {got_done, got_to}, 2);
        run_cmd(2'd2, 16'h0);
        chk(got_done && rdata_o == v, "R10 readback", rdata_o, v);
        chk(busy_o == 0, "R11 idle after done", busy_o, 0);
      end
    end
    chk(order_err == 0, "R8 capture before write", order_err, 0);
    chk(viol == 0, "R5 four-phase", viol, 0);

    // R10 data held
    @(negedge clk_i); @(negedge clk_i);
    chk(rdata_o == ((16'hA5C0 ^ 16'(2 << 9) ^ 16'(3 << 5) ^ 16'(11 << 1)) & 16'hFFFE), "R10 hold", rdata_o, 0);

    // R3 opcode 3 ignored
    begin
      logic [31:0] c0;
      @(negedge clk_i); c0 = ctrl_o;
      cmd_valid_i = 1; cmd_op_i = 2'd3; cmd_data_i = 16'h7777;
      @(negedge clk_i); cmd_valid_i = 0;
      @(negedge clk_i);
      chk(!busy_o && ctrl_o == c0, "R3 op3 ignored", ctrl_o, c0);
    end

    // R3 command while busy ignored
    poll_gap_i = 8'd5; dly = 0;
    run_cmd(2'd0, 16'd4);
    run_cmd(2'd1, 16'h1230);
    fork
      run_cmd(2'd2, 16'h0);
      begin
        repeat (4) @(negedge clk_i);
        cmd_valid_i = 1; cmd_op_i = 2'd1; cmd_data_i = 16'h4444;
        @(negedge clk_i); cmd_valid_i = 0;
      end
    join
    chk(got_done && rdata_o == 16'h1230, "R3 busy read", rdata_o, 16'h1230);
    run_cmd(2'd2, 16'h0);
    chk(rdata_o == 16'h1230, "R3 busy cmd ignored", rdata_o, 16'h1230);

    // R6 timeout in high phase
    no_ack = 1;
    for (int g = 0; g < 4; g++) begin
      poll_gap_i = 8'(g);
      run_cmd(2'd0, 16'h3);
      chk(got_to && !got_done && cyc == 2 + (g + 1) * MAXP, "R6 hi timeout cycles", cyc, 2 + (g + 1) * MAXP);
      chk(ctrl_o[19:16] == 0 && !busy_o, "R6 clean after timeout", ctrl_o, 0);
    end
    no_ack = 0;

    // R6 timeout in low phase
    ack_stuck = 1;
    poll_gap_i = 8'd1;
    run_cmd(2'd2, 16'h0);
    chk(got_to && cyc == 2 + (MAXP + 1) * 2, "R6 lo timeout cycles", cyc, 2 + (MAXP + 1) * 2);
    ack_stuck = 0;
    repeat (10) @(negedge clk_i);

    // R9 reset write
    poll_gap_i = 8'd0; no_ack_wr = 1;
    run_cmd(2'd0, 16'd9);
    run_cmd(2'd1, 16'h0001);
    chk(got_done && !got_to, "R9 reset write done", {got_done, got_to}, 2);
    chk(ctrl_o[18] == 1 && !busy_o, "R9 write strobe held", ctrl_o, 32'h40001);
    no_ack_wr = 0;
    repeat (10) @(negedge clk_i);
    run_cmd(2'd0, 16'd9);
    chk(wr_at_take == 0, "R9 strobe cleared on accept", wr_at_take, 0);
    chk(got_done, "R9 next cmd done", got_done, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule